// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks integer divider settings for a frequency synthesiser. It takes a reference frequency and a target output frequency, both in kHz. It then searches for the pre-divider N, the post-divider B and the feedback multiplier M whose output frequency, reference × M / (N × B), lies closest to the target. Software or a sequencer pulses `start` with the two frequencies on the inputs. Some time later the engine raises `done` for one cycle, with the chosen triple, the remaining error and a failure flag on its outputs.

The engine tries every pair (N, B) in a fixed order. For each pair it derives M by rounding, discards out-of-range values, and measures the error that the candidate would produce. It keeps the first candidate with the smallest error and stops early when a candidate hits the target exactly. One shared restoring divider does both divisions for each candidate: the rounded M, and the candidate output frequency. The datapath therefore stays one subtractor wide, and each candidate takes two divider passes of `FW+10` cycles each. A caller that drives a dual-channel serial display link requests seven times the pixel clock, halved when two links share the load. That scaling is done by the caller before `start`.

Top module: `pll_div_search`

## Requirements
- R1: A `start` while idle with `fin_khz` or `fout_khz` equal to 0 gives `done`=1 and `err`=1 on the next cycle. In that result `n_sel`, `b_sel` and `m_sel` are 0 and `best_err` is 1000000.
- R2: The engine visits N from 2 to 6 in an outer loop and B from 2 to 6 in an inner loop. For each pair it uses M = floor((N·B·fout + floor(fin/2)) / fin).
- R3: A pair whose M is below 1 or above 1023 is skipped. A reported `m_sel` always lies in 1..1023.
- R4: The candidate error is |floor(fin·M / (N·B)) − fout|. `best_err` reports the error of the chosen triple.
- R5: The running best starts at 1000000. A candidate replaces it only when its error is strictly smaller, so on a tie the first pair in search order is kept.
- R6: The search stops at the first candidate with zero error. When N=2, B=2 is exact, `done` rises 2·(FW+10)+1 cycles after the `start` edge.
- R7: When no candidate improves on the starting best, `err`=1, `n_sel`=`b_sel`=`m_sel`=0 and `best_err`=1000000.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted `start` until `done`. After reset all outputs are 0.
- R9: The results change only in the cycle `done` rises and hold until the next result. A `start` while `busy` is ignored: the operands that are already latched decide the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search with the present frequencies |
| fin_khz | input | FW | Reference frequency in kHz |
| fout_khz | input | FW | Target output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Input rejected or no usable candidate |
| n_sel | output | 3 | Chosen pre-divider N (0 on failure) |
| b_sel | output | 3 | Chosen post-divider B (0 on failure) |
| m_sel | output | 10 | Chosen multiplier M (0 on failure) |
| best_err | output | 20 | Error of the chosen triple in kHz |

## Verification
The bench builds the engine with `FW`=20, which gives a 30-step divider pass, and keeps the default 2..6 and 1..1023 bounds. This makes a full 25-pair sweep short enough to run many times. It still reaches both edges of the M window: a tiny reference forces M above 1023 and a huge one rounds M to 0. Frequencies near half a million kHz exercise the full width of the shared divider. Hand-worked cases check the tie-keeps-first rule and the exact-hit latency. A software model of the search covers the remaining operand pairs.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FW       = 32,
  parameter int N_MIN    = 2,
  parameter int N_MAX    = 6,
  parameter int B_MIN    = 2,
  parameter int B_MAX    = 6,
  parameter int M_MIN    = 1,
  parameter int M_MAX    = 1023,
  parameter int ERR_INIT = 1000000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [FW-1:0]                     fin_khz,
  input  logic [FW-1:0]                     fout_khz,
  output logic                              busy,
  output logic                              done,
  output logic                              err,
  output logic [$clog2(N_MAX+1)-1:0]        n_sel,
  output logic [$clog2(B_MAX+1)-1:0]        b_sel,
  output logic [$clog2(M_MAX+1)-1:0]        m_sel,
  output logic [$clog2(ERR_INIT+1)-1:0]     best_err
);
  localparam int NW = $clog2(N_MAX+1);
  localparam int BW = $clog2(B_MAX+1);
  localparam int MW = $clog2(M_MAX+1);
  localparam int EW = $clog2(ERR_INIT+1);
  localparam int PW = NW + BW;
  localparam int XW = (MW > PW + 1) ? MW : PW + 1;
  localparam int DW = FW + XW;
  localparam int CW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_DIV1, S_DIV2} state_t;
  state_t state;

  logic [FW-1:0] fin_r, fout_r, dd, dr;
  logic [DW-1:0] dq;
  logic [CW-1:0] cnt;
  logic [NW-1:0] n_c, bn;
  logic [BW-1:0] b_c, bb;
  logic [MW-1:0] m_c, bm;
  logic [EW-1:0] bbest;
  logic          found;

  function automatic logic [DW-1:0] numer_m(input logic [NW-1:0] n, input logic [BW-1:0] b,
                                             input logic [FW-1:0] fo, input logic [FW-1:0] fi);
    return DW'(n) * DW'(b) * DW'(fo) + DW'(fi >> 1);
  endfunction

  logic [FW:0]   trial;
  logic          take;
  logic [FW-1:0] rem_nx;
  logic [DW-1:0] q_nx, delta;
  logic          last, m_ok, better, wrap_b, last_pair;
  logic [NW-1:0] n_nx;
  logic [BW-1:0] b_nx;

  assign trial     = {dr, dq[DW-1]};
  assign take      = trial >= {1'b0, dd};
  assign rem_nx    = FW'(take ? trial - {1'b0, dd} : trial);
  assign q_nx      = {dq[DW-2:0], take};
  assign last      = cnt == CW'(0);
  assign m_ok      = (q_nx >= DW'(M_MIN)) && (q_nx <= DW'(M_MAX));
  assign delta     = (q_nx >= DW'(fout_r)) ? q_nx - DW'(fout_r) : DW'(fout_r) - q_nx;
  assign better    = delta < DW'(bbest);
  assign wrap_b    = b_c == BW'(B_MAX);
  assign last_pair = wrap_b && (n_c == NW'(N_MAX));
  assign n_nx      = wrap_b ? n_c + NW'(1) : n_c;
  assign b_nx      = wrap_b ? BW'(B_MIN) : b_c + BW'(1);
  assign busy      = state != S_IDLE;

  logic          fin_now, adv, load2, upd;
  logic [NW-1:0] res_n;
  logic [BW-1:0] res_b;
  logic [MW-1:0] res_m;
  logic [EW-1:0] res_e;
  logic          res_ok;

  always_comb begin
    fin_now = 1'b0;
    adv     = 1'b0;
    load2   = 1'b0;
    upd     = 1'b0;
    if (state == S_DIV1 && last) begin
      if (m_ok)           load2   = 1'b1;
      else if (last_pair) fin_now = 1'b1;
      else                adv     = 1'b1;
    end else if (state == S_DIV2 && last) begin
      upd = better;
      if (delta == DW'(0) || last_pair) fin_now = 1'b1;
      else                              adv     = 1'b1;
    end
    res_n  = upd ? n_c : bn;
    res_b  = upd ? b_c : bb;
    res_m  = upd ? m_c : bm;
    res_e  = upd ? EW'(delta) : bbest;
    res_ok = upd | found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fin_r    <= '0;
      fout_r   <= '0;
      dd       <= '0;
      dr       <= '0;
      dq       <= '0;
      cnt      <= '0;
      n_c      <= '0;
      b_c      <= '0;
      m_c      <= '0;
      bn       <= '0;
      bb       <= '0;
      bm       <= '0;
      bbest    <= '0;
      found    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      n_sel    <= '0;
      b_sel    <= '0;
      m_sel    <= '0;
      best_err <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          if (fin_khz == '0 || fout_khz == '0) begin
            done     <= 1'b1;
            err      <= 1'b1;
            n_sel    <= '0;
            b_sel    <= '0;
            m_sel    <= '0;
            best_err <= EW'(ERR_INIT);
          end else begin
            fin_r  <= fin_khz;
            fout_r <= fout_khz;
            n_c    <= NW'(N_MIN);
            b_c    <= BW'(B_MIN);
            bn     <= '0;
            bb     <= '0;
            bm     <= '0;
            bbest  <= EW'(ERR_INIT);
            found  <= 1'b0;
            dq     <= numer_m(NW'(N_MIN), BW'(B_MIN), fout_khz, fin_khz);
            dr     <= '0;
            dd     <= fin_khz;
            cnt    <= CW'(DW-1);
            state  <= S_DIV1;
          end
        end
      end else begin
        dq  <= q_nx;
        dr  <= rem_nx;
        cnt <= cnt - CW'(1);
        if (upd) begin
          bn    <= n_c;
          bb    <= b_c;
          bm    <= m_c;
          bbest <= EW'(delta);
          found <= 1'b1;
        end
        if (load2) begin
          m_c   <= q_nx[MW-1:0];
          dq    <= DW'(fin_r) * DW'(q_nx[MW-1:0]);
          dr    <= '0;
          dd    <= FW'(n_c) * FW'(b_c);
          cnt   <= CW'(DW-1);
          state <= S_DIV2;
        end
        if (adv) begin
          n_c   <= n_nx;
          b_c   <= b_nx;
          dq    <= numer_m(n_nx, b_nx, fout_r, fin_r);
          dr    <= '0;
          dd    <= fin_r;
          cnt   <= CW'(DW-1);
          state <= S_DIV1;
        end
        if (fin_now) begin
          state    <= S_IDLE;
          done     <= 1'b1;
          err      <= !res_ok;
          n_sel    <= res_ok ? res_n : '0;
          b_sel    <= res_ok ? res_b : '0;
          m_sel    <= res_ok ? res_m : '0;
          best_err <= res_ok ? res_e : EW'(ERR_INIT);
        end
      end
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int FW       = 32,
  parameter int N_MIN    = 2,
  parameter int N_MAX    = 6,
  parameter int B_MIN    = 2,
  parameter int B_MAX    = 6,
  parameter int M_MIN    = 1,
  parameter int M_MAX    = 1023,
  parameter int ERR_INIT = 1000000
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic [FW-1:0]                 fin_khz,
  input logic [FW-1:0]                 fout_khz,
  input logic                          busy,
  input logic                          done,
  input logic                          err,
  input logic [$clog2(N_MAX+1)-1:0]    n_sel,
  input logic [$clog2(B_MAX+1)-1:0]    b_sel,
  input logic [$clog2(M_MAX+1)-1:0]    m_sel,
  input logic [$clog2(ERR_INIT+1)-1:0] best_err
);
  localparam int NW = $clog2(N_MAX+1);
  localparam int BW = $clog2(B_MAX+1);
  localparam int MW = $clog2(M_MAX+1);
  localparam int EW = $clog2(ERR_INIT+1);

  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (fin_khz == '0 || fout_khz == '0)) |=> (done && err && best_err == EW'(ERR_INIT)));

  p_pair_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (n_sel >= NW'(N_MIN) && n_sel <= NW'(N_MAX) &&
                        b_sel >= BW'(B_MIN) && b_sel <= BW'(B_MAX)));

  p_m_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (m_sel >= MW'(M_MIN) && m_sel <= MW'(M_MAX)));

  p_below_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (best_err < EW'(ERR_INIT)));

  p_none_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (n_sel == '0 && b_sel == '0 && m_sel == '0 && best_err == EW'(ERR_INIT)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(n_sel) && $stable(b_sel) && $stable(m_sel) && $stable(best_err) && $stable(err)));
endmodule

bind pll_div_search pll_div_search_chk #(
  .FW(FW), .N_MIN(N_MIN), .N_MAX(N_MAX), .B_MIN(B_MIN), .B_MAX(B_MAX),
  .M_MIN(M_MIN), .M_MAX(M_MAX), .ERR_INIT(ERR_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .fin_khz(fin_khz), .fout_khz(fout_khz),
  .busy(busy), .done(done), .err(err), .n_sel(n_sel), .b_sel(b_sel),
  .m_sel(m_sel), .best_err(best_err)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
  localparam int FW = 20;
  localparam int DW = FW + 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] fin_khz = '0;
  logic [FW-1:0] fout_khz = '0;
  logic          busy, done, err;
  logic [2:0]    n_sel, b_sel;
  logic [9:0]    m_sel;
  logic [19:0]   best_err;

  int checks = 0;
  int errors = 0;
  int cycles;

  always #2 clk = ~clk;

  pll_div_search #(.FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fin_khz(fin_khz), .fout_khz(fout_khz),
    .busy(busy), .done(done), .err(err), .n_sel(n_sel), .b_sel(b_sel),
    .m_sel(m_sel), .best_err(best_err)
  );

  // fin, fout, N, B, M, error, flag
  localparam int unsigned TV [4][7] = '{
    '{24000,   48000,  2, 2, 8,  0,       0},
    '{27000,   10000,  5, 6, 11, 100,     0},
    '{1,       1000,   0, 0, 0,  1000000, 1},
    '{1000000, 1,      0, 0, 0,  1000000, 1}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint fi, input longint fo, output longint n, output longint b,
                       output longint m, output longint e, output bit fl);
    longint best;
    bit hit;
    best = 1000000; n = 0; b = 0; m = 0; hit = 0;
    for (longint i = 2; i <= 6 && !hit; i++) begin
      for (longint j = 2; j <= 6 && !hit; j++) begin
        longint mm, o, d;
        mm = (i * j * fo + fi / 2) / fi;
        if (mm < 1 || mm > 1023) continue;
        o = fi * mm / (i * j);
        d = (o >= fo) ? o - fo : fo - o;
        if (d < best) begin
          best = d; n = i; b = j; m = mm;
        end
        if (d == 0) hit = 1;
      end
    end
    e = best;
    fl = (n == 0);
  endtask

  task automatic run(input int unsigned fi, input int unsigned fo);
    @(negedge clk);
    fin_khz = FW'(fi); fout_khz = FW'(fo); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
    chk(done == 1'b1, "R8 done seen", longint'(done), 1);
  endtask

  task automatic expect_res(input string tag, input longint n, input longint b, input longint m,
                            input longint e, input bit fl);
    chk(err == fl, {tag, " R7 err"}, longint'(err), longint'(fl));
    chk(longint'(n_sel) == n, {tag, " R2 n_sel"}, longint'(n_sel), n);
    chk(longint'(b_sel) == b, {tag, " R2 b_sel"}, longint'(b_sel), b);
    chk(longint'(m_sel) == m, {tag, " R3 m_sel"}, longint'(m_sel), m);
    chk(longint'(best_err) == e, {tag, " R4 best_err"}, longint'(best_err), e);
  endtask

  task automatic after_done(input string tag);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 pulse one cycle"}, longint'(done), 0);
    chk(busy == 1'b0, {tag, " R8 idle after done"}, longint'(busy), 0);
  endtask

  initial begin
    int unsigned extra [6][2] = '{'{25000, 259875}, '{24000, 519750}, '{19200, 103},
                                  '{100000, 33333}, '{48000, 365001}, '{33333, 777}};
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R8 reset flags", longint'({busy, done, err}), 0);
    chk(n_sel == 0 && b_sel == 0 && m_sel == 0 && best_err == 0, "R8 reset results",
        longint'(m_sel), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      run(TV[k][0], TV[k][1]);
      expect_res($sformatf("table%0d R5", k), TV[k][2], TV[k][3], TV[k][4], TV[k][5], TV[k][6] != 0);
      if (k == 0) chk(cycles == 2 * DW + 1, "R6 early exit latency", cycles, 2 * DW + 1);
      after_done($sformatf("table%0d", k));
    end

    for (int k = 0; k < 6; k++) begin
      longint n, b, m, e;
      bit fl;
      model(extra[k][0], extra[k][1], n, b, m, e, fl);
      run(extra[k][0], extra[k][1]);
      expect_res($sformatf("model%0d R2", k), n, b, m, e, fl);
    end

    // R1: zero operands rejected on the next cycle
    run(0, 5000);
    chk(cycles == 1, "R1 zero fin latency", cycles, 1);
    expect_res("R1 zero fin", 0, 0, 0, 1000000, 1);
    run(24000, 0);
    chk(cycles == 1, "R1 zero fout latency", cycles, 1);
    expect_res("R1 zero fout", 0, 0, 0, 1000000, 1);

    // R9: start while busy is ignored
    @(negedge clk);
    fin_khz = FW'(27000); fout_khz = FW'(10000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R8 busy during search", longint'(busy), 1);
    chk(err == 1'b1 && m_sel == 0, "R9 hold previous result while busy", longint'(m_sel), 0);
    fin_khz = FW'(24000); fout_khz = FW'(48000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
    expect_res("R9 busy start ignored", 5, 6, 11, 100, 0);

    // R9: results hold without a start
    fin_khz = FW'(1); fout_khz = FW'(3);
    repeat (20) @(negedge clk);
    chk(done == 1'b0, "R9 no done without start", longint'(done), 0);
    expect_res("R9 hold", 5, 6, 11, 100, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule